// File: doc/BRIEF.md
# DMA Address and Byte Count Tracker

This block keeps the running bus address and the remaining byte count for one direction of a bus-master DMA engine. Software or local control logic writes a start address and a byte count through a small register port. Each time the bus side completes a data phase, it pulses a strobe. The block then moves the address on by one double word and takes four bytes off the count. For every data phase it also supplies the active-low byte-lane enables. Lanes that lie past the end of the transfer are switched off, so a count that is not a multiple of four ends in a partial phase.

A chip instantiates the block twice, once for reads and once for writes. A single count-disable signal goes to both instances. While it is set, transfers run with no length limit: the address keeps advancing and the count is frozen. A count that reaches zero stays at zero. The block raises a one-cycle terminal-count pulse at that point. Further strobes are ignored until a new count is written.

A retried or disconnected bus transaction produces no strobe. The address and count therefore stay where the last completed phase left them, and the transfer resumes from that point.

Top module: `dma_xfer_track`

## Requirements
- R1: A write to the address register stores the value with bits [1:0] forced to 0. If either of those bits was set in the written data, align_err_o is high for exactly the one cycle after the write.
- R2: An accepted phase raises addr_o by exactly 4. A phase is accepted when phase_done_i is high and either cnt_dis_i is high or cnt_o is nonzero.
- R3: With cnt_dis_i low, an accepted phase lowers cnt_o by 4. If cnt_o was below 4, it goes to 0 instead.
- R4: tc_o is high for exactly one cycle, in the cycle after an accepted phase that brings cnt_o from a nonzero value to 0. It is low at all other times.
- R5: be_no is active low, and bit n controls byte lane n. With cnt_dis_i low, be_no is 4'b0000 when cnt_o is 4 or more. It is 4'b1000 for a count of 3, 4'b1100 for 2, 4'b1110 for 1 and 4'b1111 for 0.
- R6: With cnt_dis_i low, a count of zero is sticky. Strobes leave addr_o and cnt_o unchanged, xfer_ok_o is low, and only a count write restarts the transfer.
- R7: When there is no strobe and no register write, addr_o and cnt_o hold their values. This gives an exact resume point after a retry.
- R8: While cnt_dis_i is high, strobes advance addr_o and leave cnt_o unchanged. be_no is 4'b0000, tc_o stays low and xfer_ok_o is high.
- R9: A register write in the same cycle as a strobe wins. The written value is stored with no advance applied.
- R10: After reset, addr_o and cnt_o are 0, be_no is 4'b1111, and tc_o and align_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Write strobe for the start address |
| cnt_we_i | input | 1 | Write strobe for the byte count |
| wdata_i | input | AW | Write data; the count uses the low CW bits |
| phase_done_i | input | 1 | Pulses when a data phase completes |
| cnt_dis_i | input | 1 | Global count disable: ignore the count |
| addr_o | output | AW | Current double-word address |
| cnt_o | output | CW | Remaining byte count |
| be_no | output | 4 | Active-low byte-lane enables for the current phase |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| xfer_ok_o | output | 1 | Another phase may be issued |
| align_err_o | output | 1 | One-cycle pulse after a misaligned address write |

## Verification
The hardest situation to reach is the cycle where the final partial phase completes. The lane mask must already be reduced, the count must reach exactly zero, and a strobe that follows must have no effect. The stimulus table therefore covers every count residue, 1 through 3 as well as exact multiples of four. It records the lanes shown during the last phase, then issues an extra strobe once the count is zero. A separate test applies a count write in the same cycle as a strobe, to check that the write takes precedence.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;
  localparam int unsigned LANES = 4;

  // active-low lane mask for the bytes still owed in this phase
  function automatic logic [LANES-1:0] lane_mask_n(input logic [2:0] left);
    logic [LANES-1:0] m;
    m = '1;
    for (int i = 0; i < LANES; i++) begin
      if (32'(i) < 32'(left)) m[i] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          align_err_o
);
  localparam logic [AW-1:0] STEP = AW'(dma_trk_pkg::LANES);

  logic [AW-1:0] addr_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= we_i & (|wdata_i[1:0]);
      if (we_i)       addr_q <= {wdata_i[AW-1:2], 2'b00};
      else if (adv_i) addr_q <= addr_q + STEP;
    end
  end

  assign addr_o      = addr_q;
  assign align_err_o = err_q;

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !we_i) |=> (addr_q == $past(addr_q) + STEP));
  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !we_i) |=> $stable(addr_q));
endmodule

// File: rtl/dma_byte_count.sv
module dma_byte_count #(
  parameter int unsigned CW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          dis_i,
  output logic [CW-1:0] cnt_o,
  output logic          adv_o,
  output logic          tc_o
);
  localparam logic [CW-1:0] STEP = CW'(dma_trk_pkg::LANES);

  logic [CW-1:0] cnt_q;
  logic          tc_q;
  logic          at_zero, last_phase, dec;

  assign at_zero    = (cnt_q == '0);
  assign last_phase = (cnt_q <= STEP);
  assign adv_o      = step_i & (dis_i | ~at_zero);
  assign dec        = step_i & ~dis_i & ~at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= dec & ~we_i & last_phase;
      if (we_i)     cnt_q <= wdata_i;
      else if (dec) cnt_q <= last_phase ? '0 : cnt_q - STEP;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;

  a_r4_tc_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |-> (cnt_q == '0));
  a_r6_zero_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero && !we_i) |=> (cnt_q == '0));
  a_r8_dis_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !we_i) |=> $stable(cnt_q));
  a_r3_no_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/dma_lane_decode.sv
module dma_lane_decode #(
  parameter int unsigned CW = 26
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          dis_i,
  output logic [3:0]    be_no
);
  logic [2:0] left;

  always_comb begin
    if (cnt_i >= CW'(dma_trk_pkg::LANES)) left = 3'(dma_trk_pkg::LANES);
    else                                  left = cnt_i[2:0];
    be_no = dis_i ? 4'b0000 : dma_trk_pkg::lane_mask_n(left);
  end
endmodule

// File: rtl/dma_xfer_track.sv
module dma_xfer_track #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic          cnt_we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          phase_done_i,
  input  logic          cnt_dis_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic [3:0]    be_no,
  output logic          tc_o,
  output logic          xfer_ok_o,
  output logic          align_err_o
);
  logic adv;

  dma_byte_count #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cnt_we_i),
    .wdata_i (wdata_i[CW-1:0]),
    .step_i  (phase_done_i),
    .dis_i   (cnt_dis_i),
    .cnt_o   (cnt_o),
    .adv_o   (adv),
    .tc_o    (tc_o)
  );

  dma_addr_track #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (addr_we_i),
    .wdata_i     (wdata_i),
    .adv_i       (adv),
    .addr_o      (addr_o),
    .align_err_o (align_err_o)
  );

  dma_lane_decode #(.CW(CW)) u_lane (
    .cnt_i (cnt_o),
    .dis_i (cnt_dis_i),
    .be_no (be_no)
  );

  assign xfer_ok_o = cnt_dis_i | (cnt_o != '0);

  a_r1_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> !align_err_o || $past(addr_we_i));
endmodule

// File: tb/dma_xfer_track_bench.sv
module dma_xfer_track_bench;
  localparam int AW = 32;
  localparam int CW = 26;
  localparam int NV = 8;
  localparam int V_CNT [NV] = '{10, 1, 2, 3, 4, 8, 13, 7};
  localparam int V_PH  [NV] = '{3, 1, 1, 1, 1, 2, 4, 2};
  localparam logic [3:0] V_BE [NV] =
    '{4'b1100, 4'b1110, 4'b1100, 4'b1000, 4'b0000, 4'b0000, 4'b1110, 4'b1000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_we = 1'b0, cnt_we = 1'b0, phase_done = 1'b0, cnt_dis = 1'b0;
  logic [AW-1:0] wdata = '0;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;
  logic [3:0] be_n;
  logic tc, xfer_ok, align_err;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dma_xfer_track #(.AW(AW), .CW(CW)) u_dma_xfer_track (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(addr_we), .cnt_we_i(cnt_we),
    .wdata_i(wdata), .phase_done_i(phase_done), .cnt_dis_i(cnt_dis),
    .addr_o(addr), .cnt_o(cnt), .be_no(be_n), .tc_o(tc),
    .xfer_ok_o(xfer_ok), .align_err_o(align_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_we = 1'b1; wdata = a;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic wr_cnt(input int c);
    @(negedge clk); cnt_we = 1'b1; wdata = AW'(c);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); phase_done = 1'b1;
    @(negedge clk); phase_done = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] a0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(addr == 0 && cnt == 0, "R10 addr/cnt", {addr[15:0], cnt[15:0]}, 0);
    chk(be_n == 4'b1111 && !tc && !align_err, "R10 be/tc/err", {be_n, tc, align_err}, 32'h3c);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      int n, tcs, prev;
      logic [3:0] last_be;
      a0 = 32'h1000 + 32'(i) * 32'h100;
      wr_addr(a0);
      wr_cnt(V_CNT[i]);
      n = 0; tcs = 0; last_be = 4'hx;
      while (cnt != 0 && n < 100) begin
        if (cnt >= 4) chk(be_n == 4'b0000, "R5 full lanes", 32'(be_n), 0);
        last_be = be_n;
        prev = int'(cnt);
        strobe();
        n++;
        chk(int'(cnt) == (prev < 4 ? 0 : prev - 4), "R3 count step", 32'(cnt), 32'(prev < 4 ? 0 : prev - 4));
        if (tc) tcs++;
        chk(tc == (cnt == 0), "R4 tc timing", 32'(tc), 32'(cnt == 0));
      end
      chk(n == V_PH[i], "R3 phase total", 32'(n), 32'(V_PH[i]));
      chk(last_be == V_BE[i], "R5 final lanes", 32'(last_be), 32'(V_BE[i]));
      chk(addr == a0 + 32'(4 * V_PH[i]), "R2 end address", addr, a0 + 32'(4 * V_PH[i]));
      chk(tcs == 1, "R4 single pulse", 32'(tcs), 1);
      @(negedge clk);
      chk(!tc, "R4 pulse ends", 32'(tc), 0);
    end

    // R6 strobe at zero is ignored
    a0 = addr;
    chk(be_n == 4'b1111 && !xfer_ok, "R6 idle outputs", {be_n, xfer_ok}, 32'h1e);
    strobe();
    chk(addr == a0 && cnt == 0 && !tc, "R6 strobe ignored", addr, a0);

    // R1 misaligned write
    @(negedge clk); addr_we = 1'b1; wdata = 32'h2003;
    @(negedge clk); addr_we = 1'b0;
    chk(addr == 32'h2000, "R1 forced align", addr, 32'h2000);
    chk(align_err, "R1 err pulse", 32'(align_err), 1);
    @(negedge clk);
    chk(!align_err, "R1 err clears", 32'(align_err), 0);
    wr_addr(32'h3000);
    chk(!align_err, "R1 aligned no err", 32'(align_err), 0);

    // R7 hold without strobe (retry)
    wr_cnt(12);
    strobe();
    repeat (5) @(negedge clk);
    chk(addr == 32'h3004 && cnt == 8, "R7 resume point", addr, 32'h3004);

    // R8 count disabled
    cnt_dis = 1'b1;
    @(negedge clk);
    chk(be_n == 4'b0000 && xfer_ok, "R8 lanes/ok", {be_n, xfer_ok}, 1);
    for (int k = 0; k < 3; k++) begin
      strobe();
      chk(!tc, "R8 no tc", 32'(tc), 0);
    end
    chk(addr == 32'h3010 && cnt == 8, "R8 addr moves cnt frozen", {addr[15:0], cnt[15:0]}, 32'h30100008);
    cnt_dis = 1'b0;

    // R9 write beats strobe
    @(negedge clk); cnt_we = 1'b1; phase_done = 1'b1; wdata = 32'd20;
    @(negedge clk); cnt_we = 1'b0; phase_done = 1'b0;
    chk(cnt == 20 && addr == 32'h3014, "R9 count write wins", 32'(cnt), 20);
    @(negedge clk); addr_we = 1'b1; phase_done = 1'b1; wdata = 32'h4000;
    @(negedge clk); addr_we = 1'b0; phase_done = 1'b0;
    chk(addr == 32'h4000 && cnt == 16, "R9 addr write wins", addr, 32'h4000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule